// File: doc/BRIEF.md
# Anti-Modulation Data Encoder

This block is the digital model of a radio transmitter's data buffer. It also models the integrator that offsets the drift of the synthesiser loop. It turns each transmit bit into one of three current levels. A 0 bit gives no current and a 1 bit gives twice the unit current. The midpoint of one unit is held whenever the radio is receiving or the transmit amplifier is ramping up or down. The midpoint stops the loop from settling on either data level and prevents over-modulation when a burst starts.

Beside the level code, the block keeps a signed running integral of the data, one step per bit. It rises by one step for each 0 bit and falls by one step for each 1 bit. It saturates at a bound and returns to zero in receive mode. Downstream analog logic would turn this count into a compensation current fed into the loop filter. One step stands for about 52 nA, so a run of 32 equal bits is worth about 1.67 uA.

Top module: `antimod_encoder`

## Requirements
- R1: While transmitting (`tx_en`=1) outside a ramp (`ramp`=0), a data bit of 0 gives `level` = 2'b00 (zero current) in the same cycle.
- R2: While transmitting outside a ramp, a data bit of 1 gives `level` = 2'b10 (twice the unit current) in the same cycle.
- R3: When `tx_en`=0 or `ramp`=1, `level` = 2'b01 (unit current), whatever the data bit.
- R4: `level` never takes the value 2'b11.
- R5: The conditions are `tx_en`=1, `ramp`=0 and `bit_stb`=1 at a clock edge. If the data bit is then 0, `comp_acc` grows by one after that edge, unless it is already at +SAT.
- R6: Under the same conditions as R5, a data bit of 1 makes `comp_acc` drop by one after that edge, unless it is already at -SAT.
- R7: While `tx_en`=1, `comp_acc` does not change when `bit_stb`=0 or when `ramp`=1.
- R8: `comp_acc` saturates at +SAT and -SAT (63 by default) and never wraps.
- R9: An edge with `tx_en`=0 sets `comp_acc` to zero.
- R10: After reset, `comp_acc` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_bit | input | 1 | Transmit data bit |
| bit_stb | input | 1 | One-cycle pulse marking one bit period |
| tx_en | input | 1 | 1 = transmit, 0 = receive |
| ramp | input | 1 | 1 = transmit amplifier powering up or down |
| level | output | 2 | Current level code: 00 zero, 01 unit, 10 double |
| comp_acc | output | ACC_W | Signed compensation integral (two's complement) |

## Verification
The level code is combinational, so the bench checks it one nanosecond after it drives the inputs on the falling edge. That check comes before the next rising edge. The integral is registered and is due one rising edge after a strobed bit or a receive cycle. The bench samples it one nanosecond after that edge and compares it with the bench's own count of 0 bits minus 1 bits, clamped to the bound. Long runs of identical bits drive the count into both bounds.

// File: rtl/antimod_encoder.sv
module antimod_encoder #(
  parameter int ACC_W = 7,
  parameter int SAT   = 63
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    data_bit,
  input  logic                    bit_stb,
  input  logic                    tx_en,
  input  logic                    ramp,
  output logic [1:0]              level,
  output logic signed [ACC_W-1:0] comp_acc
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = ACC_W'(SAT);
  localparam logic signed [ACC_W-1:0] ACC_MIN = -ACC_MAX;
  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1);

  logic mid_hold;
  logic step_en;

  assign mid_hold = !tx_en || ramp;
  assign step_en  = tx_en && !ramp && bit_stb;
  assign level    = mid_hold ? 2'b01 : (data_bit ? 2'b10 : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      comp_acc <= '0;
    else if (!tx_en)
      comp_acc <= '0;
    else if (step_en) begin
      if (!data_bit && comp_acc < ACC_MAX)
        comp_acc <= comp_acc + ONE;
      else if (data_bit && comp_acc > ACC_MIN)
        comp_acc <= comp_acc - ONE;
    end
  end

  p_no_code3_r4: assert property (@(posedge clk) disable iff (!rst_n)
    level != 2'b11);

  p_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    comp_acc <= ACC_MAX && comp_acc >= ACC_MIN);

  p_rx_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> comp_acc == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && (!bit_stb || ramp)) |=> $stable(comp_acc));

  p_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !ramp && bit_stb && !data_bit && comp_acc < ACC_MAX)
      |=> comp_acc == $past(comp_acc) + ONE);

  p_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !ramp && bit_stb && data_bit && comp_acc > ACC_MIN)
      |=> comp_acc == $past(comp_acc) - ONE);
endmodule

// File: tb/sim_antimod_encoder.sv
module sim_antimod_encoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data_bit = 1'b0, bit_stb = 1'b0, tx_en = 1'b0, ramp = 1'b0;
  logic [1:0] level;
  logic signed [6:0] comp_acc;
  int checks = 0, errors = 0, exp_acc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  antimod_encoder u0 (.clk(clk), .rst_n(rst_n), .data_bit(data_bit), .bit_stb(bit_stb),
                      .tx_en(tx_en), .ramp(ramp), .level(level), .comp_acc(comp_acc));

  // {tx_en, ramp, bit_stb, data_bit, expected level}
  localparam logic [5:0] VEC [10] = '{
    6'b1010_00, 6'b1011_10, 6'b1000_00, 6'b1001_10, 6'b0000_01,
    6'b0011_01, 6'b1110_01, 6'b1111_01, 6'b0110_01, 6'b1010_00 };

  function automatic logic [1:0] exp_level(logic t, logic r, logic d);
    if (!t || r) return 2'b01;
    return d ? 2'b10 : 2'b00;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(logic t, logic r, logic s, logic d);
    @(negedge clk);
    tx_en = t; ramp = r; bit_stb = s; data_bit = d;
    #1;
    chk((!t || r) ? "R3 level" : (d ? "R2 level" : "R1 level"), int'(level), int'(exp_level(t, r, d)));
    chk("R4 no code 11", int'(level == 2'b11), 0);
    if (!t) exp_acc = 0;
    else if (s && !r) begin
      if (!d && exp_acc < 63) exp_acc++;
      else if (d && exp_acc > -63) exp_acc--;
    end
    @(posedge clk); #1;
    chk(!t ? "R9 rx clear" : (!s || r) ? "R7 hold" : (d ? "R6 down" : "R5 up"),
        int'(comp_acc), exp_acc);
  endtask

  task automatic run(logic d, int n);
    for (int i = 0; i < n; i++) apply(1, 0, 1, d);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #11;
    chk("R10 reset acc", int'(comp_acc), 0);
    chk("R3 level in reset rx", int'(level), 1);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++)
      apply(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
    apply(0, 0, 0, 0);
    run(0, 32);
    chk("R5 32 zeros", int'(comp_acc), 32);
    run(1, 40);
    chk("R6 40 ones", int'(comp_acc), -8);
    apply(1, 0, 0, 0);
    apply(1, 0, 0, 1);
    apply(1, 1, 1, 0);
    apply(1, 1, 1, 1);
    chk("R7 hold during ramp", int'(comp_acc), -8);
    run(0, 80);
    chk("R8 upper bound", int'(comp_acc), 63);
    run(0, 3);
    run(1, 140);
    chk("R8 lower bound", int'(comp_acc), -63);
    run(1, 2);
    apply(1, 0, 1, 0);
    chk("R8 leaves lower bound", int'(comp_acc), -62);
    apply(0, 0, 1, 1);
    chk("R9 rx clears", int'(comp_acc), 0);
    rst_n = 1'b0; #1;
    chk("R10 async reset", int'(comp_acc), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule